// File: doc/BRIEF.md
# Dual-Mode Peripheral Bus Interface

This block sits between a host bus and a small file of 8-bit peripheral registers. Three address lines pick one register. It turns the host's control pins into clean internal strobes: a one-hot read enable with a matching data-bus output enable, and a one-hot write pulse that lasts one cycle, with the write data held in a register beside it. The register contents and the pad drivers are outside the block.

A mode pin picks one of two host protocols. In memory mode the read and write pins are active low. In I/O mode a high read pin means a read, and a write happens while the read pin is low and the write pin is high. Chip select is taken through a latch that a separate strobe opens. Tying the strobe high makes the select follow the chip-select pin. Pulsing the strobe captures the select for the bus cycles that follow. Every pin is registered once on the internal clock before decoding. All outputs are registered.

Top module: `periph_bus_if`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, rd_en, wr_pulse, dout_oe and wdata are all zero, and the select latch is cleared.
- R2: Memory mode (io_mode = 0), selected, with rd_n low and wr_n high: on the second rising clock edge after the pins settle, rd_en equals one-hot of addr (bit addr set) and dout_oe is 1.
- R3: Memory mode, selected: a write window lasts while wr_n is low. On the second rising edge after the window ends, wr_pulse has exactly bit A set for one cycle and wdata takes D. A and D are the addr and din values of the window's last cycle.
- R4: Memory mode with rd_n and wr_n both low counts as a write. rd_en and dout_oe stay zero throughout.
- R5: I/O mode (io_mode = 1), selected, with rd_n high: rd_en equals one-hot of addr and dout_oe is 1, with the same latency as R2.
- R6: I/O mode, selected: a write window lasts while rd_n is low and wr_n is high. When it ends (wr_n falls), one wr_pulse and a wdata update follow as in R3. dout_oe stays zero during the window.
- R7: While stb is high the select follows cs. While stb is low the select keeps the cs value sampled on the last cycle that stb was high.
- R8: When not selected, no read enable, no output enable and no write pulse occur, and wdata keeps its value.
- R9: rd_en has at most one bit set, and dout_oe is 1 exactly when some rd_en bit is set.
- R10: wr_pulse has at most one bit set and never stays high for two cycles in a row. wdata changes only in a cycle where a pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| io_mode | input | 1 | 0 = memory protocol, 1 = I/O protocol |
| stb | input | 1 | Select-latch strobe, latch open while high |
| cs | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read pin (low active in memory mode, high active in I/O mode) |
| wr_n | input | 1 | Write pin (low active in memory mode, high active in I/O mode) |
| addr | input | 3 | Register address |
| din | input | 8 | Write data from host |
| rd_en | output | 8 | One-hot read enable per register |
| dout_oe | output | 1 | Data-bus output enable |
| wr_pulse | output | 8 | One-hot single-cycle write strobe per register |
| wdata | output | 8 | Write data captured at the end of the write window |

## Verification
If the select latch holds a wrong value, reads and writes after a strobe pulse either vanish or appear where none were expected. This shows on rd_en or wr_pulse two cycles after the host cycle. If the write-window tracking is wrong, a pulse goes missing, a pulse is doubled, or a pulse carries the wrong address or data. A scoreboard compares each pulse against the queued host write as it appears. A polarity mix-up between modes turns a write into a read, and dout_oe then rises during a write window within two cycles.

// File: rtl/bif_pkg.sv
package bif_pkg;
  typedef enum logic { MODE_MEM = 1'b0, MODE_IO = 1'b1 } bus_mode_e;

  function automatic logic [7:0] onehot8(input logic [2:0] idx);
    logic [7:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bif_pin_sampler.sv
module bif_pin_sampler #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_mode,
  input  logic          stb,
  input  logic          cs,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          s_mode,
  output logic          s_stb,
  output logic          s_cs,
  output logic          s_rd,
  output logic          s_wr,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_din
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_mode <= 1'b0;
      s_stb  <= 1'b0;
      s_cs   <= 1'b0;
      s_rd   <= 1'b1;
      s_wr   <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_mode <= io_mode;
      s_stb  <= stb;
      s_cs   <= cs;
      s_rd   <= rd_n;
      s_wr   <= wr_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end
endmodule

// File: rtl/bif_select_latch.sv
module bif_select_latch (
  input  logic clk,
  input  logic rst,
  input  logic s_stb,
  input  logic s_cs,
  output logic sel
);
  logic held_q;

  // Open while strobe is high; keep last captured value otherwise.
  assign sel = s_stb ? s_cs : held_q;

  always_ff @(posedge clk) begin
    if (rst)        held_q <= 1'b0;
    else if (s_stb) held_q <= s_cs;
  end
endmodule

// File: rtl/bif_cycle_decode.sv
module bif_cycle_decode
  import bif_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8,
  localparam int NREG = 1 << AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_mode,
  input  logic            s_rd,
  input  logic            s_wr,
  input  logic [AW-1:0]   s_addr,
  input  logic [DW-1:0]   s_din,
  input  logic            sel,
  output logic [NREG-1:0] rd_en,
  output logic            dout_oe,
  output logic [NREG-1:0] wr_pulse,
  output logic [DW-1:0]   wdata
);
  logic read_lvl, write_lvl, commit;
  logic win_q;
  logic [AW-1:0] last_addr_q;
  logic [DW-1:0] last_din_q;

  always_comb begin
    if (bus_mode_e'(s_mode) == MODE_MEM) begin
      write_lvl = sel & ~s_wr;
      read_lvl  = sel & ~s_rd & s_wr;
    end else begin
      write_lvl = sel & ~s_rd & s_wr;
      read_lvl  = sel & s_rd;
    end
  end

  assign commit = win_q & ~write_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q       <= 1'b0;
      last_addr_q <= '0;
      last_din_q  <= '0;
      dout_oe     <= 1'b0;
      wdata       <= '0;
    end else begin
      win_q <= write_lvl;
      if (write_lvl) begin
        last_addr_q <= s_addr;
        last_din_q  <= s_din;
      end
      dout_oe <= read_lvl;
      if (commit) wdata <= last_din_q;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_en[g]    <= 1'b0;
        wr_pulse[g] <= 1'b0;
      end else begin
        rd_en[g]    <= read_lvl & (s_addr == AW'(g));
        wr_pulse[g] <= commit & (last_addr_q == AW'(g));
      end
    end
  end
endmodule

// File: rtl/periph_bus_if.sv
module periph_bus_if #(
  parameter int AW = 3,
  parameter int DW = 8,
  localparam int NREG = 1 << AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_mode,
  input  logic            stb,
  input  logic            cs,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  output logic [NREG-1:0] rd_en,
  output logic            dout_oe,
  output logic [NREG-1:0] wr_pulse,
  output logic [DW-1:0]   wdata
);
  logic          s_mode, s_stb, s_cs, s_rd, s_wr, sel;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_din;

  bif_pin_sampler #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .io_mode(io_mode), .stb(stb), .cs(cs),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .s_mode(s_mode), .s_stb(s_stb), .s_cs(s_cs), .s_rd(s_rd),
    .s_wr(s_wr), .s_addr(s_addr), .s_din(s_din)
  );

  bif_select_latch u_sel (
    .clk(clk), .rst(rst), .s_stb(s_stb), .s_cs(s_cs), .sel(sel)
  );

  bif_cycle_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .s_mode(s_mode), .s_rd(s_rd), .s_wr(s_wr),
    .s_addr(s_addr), .s_din(s_din), .sel(sel),
    .rd_en(rd_en), .dout_oe(dout_oe), .wr_pulse(wr_pulse), .wdata(wdata)
  );
endmodule

// File: rtl/periph_bus_if_chk.sv
module periph_bus_if_chk #(
  parameter int NREG = 8,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] rd_en,
  input logic            dout_oe,
  input logic [NREG-1:0] wr_pulse,
  input logic [DW-1:0]   wdata
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_en == '0 && wr_pulse == '0 && !dout_oe && wdata == '0));

  a_r9_rd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en));

  a_r9_oe_matches: assert property (@(posedge clk) disable iff (rst)
    dout_oe == (rd_en != '0));

  a_r10_wr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_pulse));

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse != '0) |=> (wr_pulse == '0));

  a_r10_wdata_moves_on_pulse: assert property (@(posedge clk) disable iff (rst)
    !$stable(wdata) |-> (wr_pulse != '0));
endmodule

bind periph_bus_if periph_bus_if_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .dout_oe(dout_oe),
  .wr_pulse(wr_pulse), .wdata(wdata)
);

// File: tb/periph_bus_if_test.sv
module periph_bus_if_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_mode = 1'b0, stb = 1'b1, cs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] rd_en, wr_pulse, wdata;
  logic dout_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct packed { logic [2:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_bus_if uut (
    .clk(clk), .rst(rst), .io_mode(io_mode), .stb(stb), .cs(cs),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .rd_en(rd_en), .dout_oe(dout_oe), .wr_pulse(wr_pulse), .wdata(wdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Pins must be stable for two rising edges before read outputs show.
  task automatic check_read(input string req, input logic [7:0] exp_rd, input logic exp_oe);
    tick(2);
    @(negedge clk);
    check(rd_en == exp_rd, req, rd_en, exp_rd);
    check(dout_oe == exp_oe, req, dout_oe, exp_oe);
    tick(1);
  endtask

  // Scoreboard monitor: every write pulse must match the oldest queued write.
  always @(negedge clk) begin
    if (!rst && wr_pulse != '0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R10 unexpected pulse", wr_pulse, 0);
      end else begin
        wr_item_t it;
        logic [7:0] oh;
        it = exp_q.pop_front();
        oh = 8'b1 << it.a;
        check(wr_pulse == oh, "R3/R6 pulse address", wr_pulse, oh);
        check(wdata == it.d, "R3/R6 write data", wdata, it.d);
      end
    end
  end

  task automatic mem_write(input logic [2:0] a, input logic [7:0] d, input logic rd_also);
    addr = a; din = d; rd_n = ~rd_also; wr_n = 1'b0;
    tick(2);
    @(negedge clk);
    check(dout_oe == 1'b0, "R4 no drive in write window", dout_oe, 0);
    check(rd_en == '0, "R4 no read enable in write window", rd_en, 0);
    tick(1);
    exp_q.push_back('{a: a, d: d});
    wr_n = 1'b1; rd_n = 1'b1;
    tick(3);
  endtask

  task automatic io_write(input logic [2:0] a, input logic [7:0] d, input bit expect_pulse);
    addr = a; din = d; rd_n = 1'b0; wr_n = 1'b1;
    tick(2);
    @(negedge clk);
    check(dout_oe == 1'b0, "R6 no drive in write window", dout_oe, 0);
    tick(1);
    if (expect_pulse) exp_q.push_back('{a: a, d: d});
    wr_n = 1'b0;
    tick(4);
  endtask

  initial begin
    fork
      begin
        tick(3);
        @(negedge clk);
        check(rd_en == '0 && wr_pulse == '0, "R1 strobes cleared", {rd_en, wr_pulse}, 0);
        check(dout_oe == 1'b0 && wdata == '0, "R1 oe and data cleared", {dout_oe, wdata}, 0);
        tick(1);
        rst = 1'b0;
        tick(1);
        @(negedge clk);
        check(rd_en == '0 && !dout_oe, "R1 first cycle after reset", {rd_en, dout_oe}, 0);
        tick(1);

        // Memory mode, strobe tied high: select follows cs.
        cs = 1'b1; addr = 3'd5; rd_n = 1'b0;
        check_read("R2 read addr 5", 8'h20, 1'b1);
        addr = 3'd0;
        check_read("R2 R9 read addr 0", 8'h01, 1'b1);
        cs = 1'b0;
        check_read("R8 R7 deselected read", 8'h00, 1'b0);
        rd_n = 1'b1; cs = 1'b1;

        mem_write(3'd3, 8'hA5, 1'b0);   // R3
        mem_write(3'd7, 8'h3C, 1'b0);   // R3
        mem_write(3'd2, 8'h11, 1'b1);   // R4: both pins low
        check(wdata == 8'h11, "R3 wdata held after pulse", wdata, 8'h11);

        // Switch to I/O mode with the bus idle and deselected.
        cs = 1'b0; tick(1);
        rd_n = 1'b0; wr_n = 1'b0; io_mode = 1'b1; tick(2);
        stb = 1'b0; tick(1);
        cs = 1'b1; stb = 1'b1; tick(1);
        stb = 1'b0; tick(1);
        cs = 1'b0;   // R7: latch holds the selection
        addr = 3'd6; rd_n = 1'b1;
        check_read("R5 R7 I/O read addr 6", 8'h40, 1'b1);
        rd_n = 1'b0;
        tick(2);

        io_write(3'd1, 8'h77, 1'b1);    // R6
        io_write(3'd4, 8'hC3, 1'b1);    // R6

        // Strobe pulse with cs low deselects; later cs high is ignored.
        stb = 1'b1; cs = 1'b0; tick(1);
        stb = 1'b0; tick(1);
        cs = 1'b1;
        addr = 3'd2; rd_n = 1'b1;
        check_read("R7 R8 latched deselect read", 8'h00, 1'b0);
        rd_n = 1'b0;
        tick(2);
        io_write(3'd5, 8'h99, 1'b0);    // R8: no pulse expected
        @(negedge clk);
        check(wdata == 8'hC3, "R8 wdata unchanged when deselected", wdata, 8'hC3);
        tick(4);
        check(exp_q.size() == 0, "R3 R6 R10 all queued writes seen", exp_q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule